// File: doc/BRIEF.md
# Masked Packed Single-Precision Vector Multiplier

This execution unit multiplies two vectors of IEEE-754 binary32 elements lane by lane. A vector holds up to sixteen 32-bit lanes; lane j sits in bits [32j+31:32j]. A two-bit length code picks how many lanes take part: 4, 8 or 16. A per-lane write mask decides which lanes take a product. A lane with a clear mask bit either keeps the old destination lane (merge) or is cleared (zero). The second operand can be a memory-sourced scalar that is copied to every lane. The rounding mode normally comes from a control-register field. Only a full-length, register-sourced operation with the override bit set uses the static field from the operation itself.

Operations enter on a valid/ready port and leave one cycle later from a single output register, also valid/ready. The upstream may present an operation whenever it likes. It is taken on a clock edge where `in_valid` and `in_ready` are both high. `in_ready` is high whenever the output register is empty or is being read in the same cycle. A result that is not taken stays unchanged until `out_ready` rises. Each result carries five exception flags. These are the OR of the flags raised by the lanes that actually multiplied.

Top module: `vmul_unit`

## Requirements
- R1: After reset `out_valid` is 0 and `in_ready` is 1. An operation taken on a clock edge appears on `out_valid`/`out_dst`/`out_flags` right after that edge. While `out_valid` is 1 and `out_ready` is 0, the output holds steady and `in_ready` is 0.
- R2: `vlen` 0, 1 and 2 select 4, 8 and 16 active lanes. Lane j uses bits [32j+31:32j] of each operand and of the result. Code 3 acts as 2.
- R3: With `legacy` low, every result lane at or above the active lane count is zero.
- R4: When `mask_en` is 0, every active lane is multiplied. When `mask_en` is 1, an active lane j is multiplied only if `wmask[j]` is 1.
- R5: An active lane that is not multiplied takes the old destination lane when `zero_mode` is 0, and zero when `zero_mode` is 1.
- R6: When `bcast` and `src2_mem` are both 1 (and `legacy` is 0), every lane multiplies by `src2[31:0]`. Otherwise each lane uses its own `src2` element.
- R7: The rounding mode is `rc_static` when `vlen` selects 16 lanes, `bcast` is 1 and `src2_mem` is 0. In every other case it is `rc_csr`.
- R8: Rounding codes: 0 is to nearest, ties to even. 1 is toward minus infinity. 2 is toward plus infinity. 3 is toward zero. Every product is correctly rounded under the selected mode.
- R9: A NaN operand yields that NaN made quiet, taking `src1` first. A signalling NaN raises invalid. Infinity times zero yields 0x7FC00000 and raises invalid. Infinity times a nonzero finite value yields a signed infinity. Zero results carry the XOR of the signs.
- R10: Subnormal operands are used at full precision and raise denormal when no operand is NaN. An overflow gives infinity, or the largest finite value when the mode rounds toward zero or away from the sign. It raises overflow and inexact. Underflow is raised when the exponent before rounding is below the normal range and the result is inexact.
- R11: `out_flags` bit 0 is invalid, bit 1 denormal, bit 2 overflow, bit 3 underflow, bit 4 inexact. It is the OR over multiplied lanes only.
- R12: With `legacy` high, lanes 0 to 3 are multiplied regardless of `vlen`, `mask_en` and `bcast`, using `rc_csr`. Bits 511:128 of the result equal those of `old_dst`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | Operation present |
| in_ready | output | 1 | Unit can take an operation |
| src1 | input | 512 | First source vector |
| src2 | input | 512 | Second source vector or memory scalar |
| old_dst | input | 512 | Prior destination value for merging |
| wmask | input | 16 | Per-lane write mask |
| mask_en | input | 1 | Write mask in use |
| zero_mode | input | 1 | 1 clears unselected lanes, 0 merges |
| vlen | input | 2 | Vector length code |
| bcast | input | 1 | Broadcast / static-rounding control bit |
| src2_mem | input | 1 | Second source came from memory |
| legacy | input | 1 | Legacy 128-bit form |
| rc_static | input | 2 | Per-operation rounding code |
| rc_csr | input | 2 | Control-register rounding code |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Consumer takes result |
| out_dst | output | 512 | Result vector |
| out_flags | output | 5 | Exception flags of the result |

## Verification
The bench covers several corner cases, and each one has a typical failure:
- Rounding: products one ulp above 1.0 under all four modes and both signs. A swapped mode code or a lost sticky bit gives an off-by-one mantissa.
- Overflow: overflows under nearest and toward-zero rounding. A design that always saturates to infinity fails here.
- Subnormal ties: a product halfway between zero and the smallest subnormal. Tininess or the even rule, if wrong, shows up as a flipped low bit or a missing underflow flag.
- Lane selection: random operations mix lengths, masks, merge/zero, broadcast and legacy. Swapped merge and zero, a broadcast taken from a register operand, or upper lanes left dirty each give whole-lane mismatches.
- Flag gating: an invalid-raising lane is masked off. A unit that ORs flags from every lane reports invalid by mistake.
- Stalls: a stall of several cycles exposes a result that changes while blocked.

// File: rtl/vmul_pkg.sv
`timescale 1ns/1ps
package vmul_pkg;
  localparam int EW = 32;

  typedef enum logic [1:0] {
    RM_NEAR = 2'b00,
    RM_DOWN = 2'b01,
    RM_UP   = 2'b10,
    RM_ZERO = 2'b11
  } rmode_t;

  typedef struct packed {
    logic inexact;
    logic underflow;
    logic overflow;
    logic denormal;
    logic invalid;
  } fpflags_t;

  localparam logic [EW-1:0] QNAN_DEFAULT = 32'h7FC0_0000;
endpackage

// File: rtl/fp32_mul_lane.sv
`timescale 1ns/1ps
module fp32_mul_lane
  import vmul_pkg::*;
(
  input  logic [EW-1:0] a,
  input  logic [EW-1:0] b,
  input  rmode_t        rm,
  output logic [EW-1:0] res,
  output fpflags_t      flags
);
  localparam int PW = 48;

  logic [7:0]  ea, eb;
  logic [22:0] fa, fb;
  logic        a_zero, b_zero, a_sub, b_sub, a_inf, b_inf, a_nan, b_nan;
  logic        sgn;
  logic [23:0] siga, sigb;
  logic [PW-1:0] prod;

  assign ea = a[30:23];
  assign eb = b[30:23];
  assign fa = a[22:0];
  assign fb = b[22:0];
  assign a_zero = (ea == 8'd0) && (fa == '0);
  assign b_zero = (eb == 8'd0) && (fb == '0);
  assign a_sub  = (ea == 8'd0) && (fa != '0);
  assign b_sub  = (eb == 8'd0) && (fb != '0);
  assign a_inf  = (ea == 8'hFF) && (fa == '0);
  assign b_inf  = (eb == 8'hFF) && (fb == '0);
  assign a_nan  = (ea == 8'hFF) && (fa != '0);
  assign b_nan  = (eb == 8'hFF) && (fb != '0);
  assign sgn    = a[31] ^ b[31];
  assign siga   = {(ea != 8'd0), fa};
  assign sigb   = {(eb != 8'd0), fb};
  assign prod   = {24'd0, siga} * {24'd0, sigb};

  function automatic logic [5:0] lead_one(input logic [PW-1:0] v);
    logic [5:0] pos;
    pos = '0;
    for (int i = 0; i < PW; i++) if (v[i]) pos = 6'(i);
    return pos;
  endfunction

  logic [5:0]    lz;
  logic [PW-1:0] norm, shr, lostmask;
  int            ebias, dsh;
  logic [8:0]    expf;
  logic          tiny, lost, guard, stick, inexact, inc;
  logic [23:0]   sig;
  logic [31:0]   packed_sum;
  logic          ovf;

  always_comb begin
    lz    = lead_one(prod);
    norm  = prod << (6'd47 - lz);
    ebias = int'(lz) + int'(ea == 8'd0 ? 8'd1 : ea)
          + int'(eb == 8'd0 ? 8'd1 : eb) - 173;
    tiny  = (ebias < 1);
    dsh   = tiny ? (1 - ebias) : 0;
    lostmask = '0;
    if (dsh >= PW) begin
      shr  = '0;
      lost = |norm;
    end else begin
      shr      = norm >> dsh;
      lostmask = (48'd1 << dsh) - 48'd1;
      lost     = |(norm & lostmask);
    end
    expf    = tiny ? 9'd0 : ebias[8:0];
    sig     = shr[47:24];
    guard   = shr[23];
    stick   = (|shr[22:0]) | lost;
    inexact = guard | stick;
    case (rm)
      RM_NEAR: inc = guard & (stick | sig[0]);
      RM_DOWN: inc = sgn & inexact;
      RM_UP:   inc = ~sgn & inexact;
      default: inc = 1'b0;
    endcase
    packed_sum = {expf, sig[22:0]} + {31'd0, inc};
    ovf = (packed_sum[31:23] >= 9'd255);
  end

  always_comb begin
    res   = '0;
    flags = '0;
    if (a_nan || b_nan) begin
      res = a_nan ? {a[31], 8'hFF, 1'b1, fa[21:0]} : {b[31], 8'hFF, 1'b1, fb[21:0]};
      flags.invalid = (a_nan && !fa[22]) || (b_nan && !fb[22]);
    end else if ((a_inf && b_zero) || (a_zero && b_inf)) begin
      res = QNAN_DEFAULT;
      flags.invalid = 1'b1;
      flags.denormal = a_sub | b_sub;
    end else if (a_inf || b_inf) begin
      res = {sgn, 8'hFF, 23'd0};
      flags.denormal = a_sub | b_sub;
    end else if (a_zero || b_zero) begin
      res = {sgn, 31'd0};
      flags.denormal = a_sub | b_sub;
    end else begin
      flags.denormal = a_sub | b_sub;
      if (ovf) begin
        flags.overflow = 1'b1;
        flags.inexact  = 1'b1;
        if (rm == RM_ZERO || (rm == RM_DOWN && !sgn) || (rm == RM_UP && sgn))
          res = {sgn, 8'hFE, 23'h7FFFFF};
        else
          res = {sgn, 8'hFF, 23'd0};
      end else begin
        res = {sgn, packed_sum[30:0]};
        flags.inexact   = inexact;
        flags.underflow = tiny & inexact;
      end
    end
  end
endmodule

// File: rtl/vmul_ctrl.sv
`timescale 1ns/1ps
module vmul_ctrl
  import vmul_pkg::*;
#(
  parameter int LANES = 16
) (
  input  logic [1:0]       vlen,
  input  logic [LANES-1:0] wmask,
  input  logic             mask_en,
  input  logic             zero_mode,
  input  logic             bcast,
  input  logic             src2_mem,
  input  logic             legacy,
  input  logic [1:0]       rc_static,
  input  logic [1:0]       rc_csr,
  output rmode_t           rm,
  output logic             use_bcast,
  output logic [LANES-1:0] do_mul,
  output logic [LANES-1:0] keep_old
);
  localparam int LEG_LANES = LANES / 4;
  localparam int CW = $clog2(LANES + 1);

  logic [CW-1:0] nact;
  logic          full_len;

  always_comb begin
    case (vlen)
      2'd0:    nact = CW'(LANES / 4);
      2'd1:    nact = CW'(LANES / 2);
      default: nact = CW'(LANES);
    endcase
    full_len  = (vlen[1] == 1'b1);
    use_bcast = bcast & src2_mem & ~legacy;
    if (!legacy && full_len && bcast && !src2_mem) rm = rmode_t'(rc_static);
    else                                           rm = rmode_t'(rc_csr);
  end

  for (genvar j = 0; j < LANES; j++) begin : g_sel
    always_comb begin
      if (legacy) begin
        do_mul[j]   = (j < LEG_LANES);
        keep_old[j] = (j >= LEG_LANES);
      end else if (CW'(j) >= nact) begin
        do_mul[j]   = 1'b0;
        keep_old[j] = 1'b0;
      end else if (!mask_en || wmask[j]) begin
        do_mul[j]   = 1'b1;
        keep_old[j] = 1'b0;
      end else begin
        do_mul[j]   = 1'b0;
        keep_old[j] = ~zero_mode;
      end
    end
  end
endmodule

// File: rtl/vmul_unit.sv
`timescale 1ns/1ps
module vmul_unit
  import vmul_pkg::*;
#(
  parameter int LANES = 16,
  localparam int DW = LANES * EW
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [DW-1:0]    src1,
  input  logic [DW-1:0]    src2,
  input  logic [DW-1:0]    old_dst,
  input  logic [LANES-1:0] wmask,
  input  logic             mask_en,
  input  logic             zero_mode,
  input  logic [1:0]       vlen,
  input  logic             bcast,
  input  logic             src2_mem,
  input  logic             legacy,
  input  logic [1:0]       rc_static,
  input  logic [1:0]       rc_csr,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [DW-1:0]    out_dst,
  output logic [4:0]       out_flags
);
  rmode_t           rm;
  logic             use_bcast;
  logic [LANES-1:0] do_mul, keep_old;
  logic [DW-1:0]    dst_c;
  fpflags_t         lane_fl [LANES];
  fpflags_t         fl_c;

  vmul_ctrl #(.LANES(LANES)) u_ctrl (
    .vlen(vlen), .wmask(wmask), .mask_en(mask_en), .zero_mode(zero_mode),
    .bcast(bcast), .src2_mem(src2_mem), .legacy(legacy),
    .rc_static(rc_static), .rc_csr(rc_csr),
    .rm(rm), .use_bcast(use_bcast), .do_mul(do_mul), .keep_old(keep_old)
  );

  for (genvar j = 0; j < LANES; j++) begin : g_lane
    logic [EW-1:0] opa, opb, prod;
    fpflags_t      fl;
    assign opa = src1[j*EW +: EW];
    assign opb = use_bcast ? src2[EW-1:0] : src2[j*EW +: EW];
    fp32_mul_lane u_mul (.a(opa), .b(opb), .rm(rm), .res(prod), .flags(fl));
    assign dst_c[j*EW +: EW] = do_mul[j]   ? prod :
                               keep_old[j] ? old_dst[j*EW +: EW] : '0;
    assign lane_fl[j] = do_mul[j] ? fl : '0;
  end

  always_comb begin
    fl_c = '0;
    for (int j = 0; j < LANES; j++) fl_c = fl_c | lane_fl[j];
  end

  logic take;
  assign in_ready = ~out_valid | out_ready;
  assign take     = in_valid & in_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_dst   <= '0;
      out_flags <= '0;
    end else begin
      if (take) begin
        out_valid <= 1'b1;
        out_dst   <= dst_c;
        out_flags <= fl_c;
      end else if (out_ready) begin
        out_valid <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/vmul_unit_chk.sv
`timescale 1ns/1ps
module vmul_unit_chk #(
  parameter int LANES = 16,
  localparam int DW = LANES * 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_valid,
  input logic             in_ready,
  input logic [DW-1:0]    old_dst,
  input logic [LANES-1:0] wmask,
  input logic             mask_en,
  input logic             zero_mode,
  input logic [1:0]       vlen,
  input logic             legacy,
  input logic             out_valid,
  input logic             out_ready,
  input logic [DW-1:0]    out_dst,
  input logic [4:0]       out_flags
);
  logic take;
  assign take = in_valid & in_ready;

  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_dst) && $stable(out_flags)); // R1
  AST_STALL_BLOCK: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |-> !in_ready); // R1
  AST_TAKE_SHOWS: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> out_valid); // R1
  AST_SHORT_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    take && !legacy && vlen == 2'd0 |=> out_dst[DW-1:DW/4] == '0); // R3
  AST_ALL_MASKED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    take && !legacy && mask_en && zero_mode && wmask == '0 |=> out_dst == '0 && out_flags == '0); // R5
  AST_ALL_MASKED_MERGE: assert property (@(posedge clk) disable iff (!rst_n)
    take && !legacy && mask_en && !zero_mode && wmask == '0 && vlen[1]
    |=> out_dst == $past(old_dst) && out_flags == '0); // R5
  AST_LEGACY_UPPER: assert property (@(posedge clk) disable iff (!rst_n)
    take && legacy |=> out_dst[DW-1:DW/4] == $past(old_dst[DW-1:DW/4])); // R12
endmodule

bind vmul_unit vmul_unit_chk #(.LANES(LANES)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .old_dst(old_dst), .wmask(wmask), .mask_en(mask_en), .zero_mode(zero_mode),
  .vlen(vlen), .legacy(legacy), .out_valid(out_valid), .out_ready(out_ready),
  .out_dst(out_dst), .out_flags(out_flags)
);

// File: tb/sim_vmul_unit.sv
`timescale 1ns/1ps
module sim_vmul_unit;
  localparam int L = 16;
  localparam int DW = L * 32;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0, in_ready;
  logic [DW-1:0] src1 = '0, src2 = '0, old_dst = '0;
  logic [L-1:0] wmask = '0;
  logic mask_en = 1'b0, zero_mode = 1'b0, bcast = 1'b0, src2_mem = 1'b0, legacy = 1'b0;
  logic [1:0] vlen = 2'd0, rc_static = 2'd0, rc_csr = 2'd0;
  logic out_valid, out_ready = 1'b1;
  logic [DW-1:0] out_dst;
  logic [4:0] out_flags;

  int total = 0, bad = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  vmul_unit u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .src1(src1), .src2(src2), .old_dst(old_dst), .wmask(wmask),
    .mask_en(mask_en), .zero_mode(zero_mode), .vlen(vlen), .bcast(bcast),
    .src2_mem(src2_mem), .legacy(legacy), .rc_static(rc_static), .rc_csr(rc_csr),
    .out_valid(out_valid), .out_ready(out_ready), .out_dst(out_dst), .out_flags(out_flags)
  );

  task automatic check(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] rnd_fp();
    return {1'($urandom), 8'(64 + $urandom % 127), 11'($urandom), 12'd0};
  endfunction

  // exact product of two operands whose low 12 mantissa bits are zero
  function automatic logic [31:0] exact_mul(input logic [31:0] a, input logic [31:0] b);
    int unsigned ia, ib, p;
    int e;
    ia = {1'b1, a[22:12]};
    ib = {1'b1, b[22:12]};
    p = ia * ib;
    if (p >= (1 << 23)) begin
      e = int'(a[30:23]) + int'(b[30:23]) - 126;
      return {a[31] ^ b[31], 8'(e), 23'(p)};
    end
    e = int'(a[30:23]) + int'(b[30:23]) - 127;
    return {a[31] ^ b[31], 8'(e), 22'(p), 1'b0};
  endfunction

  function automatic logic [DW-1:0] exp_vec();
    logic [DW-1:0] r;
    int n;
    r = '0;
    n = (vlen == 2'd0) ? 4 : (vlen == 2'd1) ? 8 : 16;
    for (int j = 0; j < L; j++) begin
      logic [31:0] bop;
      bop = (bcast && src2_mem && !legacy) ? src2[31:0] : src2[j*32 +: 32];
      if (legacy) begin
        r[j*32 +: 32] = (j < 4) ? exact_mul(src1[j*32 +: 32], src2[j*32 +: 32]) : old_dst[j*32 +: 32];
      end else if (j >= n) begin
        r[j*32 +: 32] = '0;
      end else if (!mask_en || wmask[j]) begin
        r[j*32 +: 32] = exact_mul(src1[j*32 +: 32], bop);
      end else begin
        r[j*32 +: 32] = zero_mode ? 32'd0 : old_dst[j*32 +: 32];
      end
    end
    return r;
  endfunction

  task automatic issue();
    @(negedge clk);
    in_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic fill_old();
    for (int j = 0; j < L; j++) old_dst[j*32 +: 32] = 32'hA500_0000 | j;
  endtask

  // two-lane directed case: lanes 0 and 1 in a 4-lane vector
  task automatic pair(input string tag, input logic [31:0] a0, input logic [31:0] b0,
                      input logic [31:0] a1, input logic [31:0] b1, input logic [1:0] msk,
                      input logic zm, input logic [1:0] rc,
                      input logic [31:0] e0, input logic [31:0] e1, input logic [4:0] ef);
    logic [DW-1:0] ev;
    src1 = '0; src2 = '0; fill_old();
    src1[31:0] = a0; src2[31:0] = b0; src1[63:32] = a1; src2[63:32] = b1;
    wmask = '0; wmask[1:0] = msk; mask_en = 1'b1; zero_mode = zm;
    vlen = 2'd0; bcast = 1'b0; src2_mem = 1'b0; legacy = 1'b0; rc_csr = rc; rc_static = 2'd0;
    ev = '0;
    ev[31:0] = e0; ev[63:32] = e1;
    ev[95:64]  = zm ? 32'd0 : old_dst[95:64];
    ev[127:96] = zm ? 32'd0 : old_dst[127:96];
    issue();
    check({tag, " data"}, out_dst, ev);
    check({tag, " flags"}, {{(DW-5){1'b0}}, out_flags}, {{(DW-5){1'b0}}, ef});
  endtask

  task automatic one(input string tag, input logic [31:0] a, input logic [31:0] b,
                     input logic [1:0] rc, input logic [31:0] e, input logic [4:0] ef);
    pair(tag, a, b, 32'd0, 32'd0, 2'b01, 1'b1, rc, e, 32'd0, ef);
  endtask

  initial begin
    #400000;
    if (!finished) begin
      bad++;
      total++;
      $display("FAIL R1 watchdog act=running exp=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [DW-1:0] held;
    void'($urandom(32'd2024));
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R1 reset out_valid", {{(DW-1){1'b0}}, out_valid}, '0);
    check("R1 reset in_ready", {{(DW-1){1'b0}}, in_ready}, {{(DW-1){1'b0}}, 1'b1});
    rst_n = 1'b1;

    // R8 rounding modes, positive and negative
    one("R8 near pos", 32'h3F80_0001, 32'h3F80_0001, 2'd0, 32'h3F80_0002, 5'b10000);
    one("R8 up pos",   32'h3F80_0001, 32'h3F80_0001, 2'd2, 32'h3F80_0003, 5'b10000);
    one("R8 down neg", 32'hBF80_0001, 32'h3F80_0001, 2'd1, 32'hBF80_0003, 5'b10000);
    one("R8 zero neg", 32'hBF80_0001, 32'h3F80_0001, 2'd3, 32'hBF80_0002, 5'b10000);
    one("R8 exact one", 32'h3F80_0000, 32'h4040_0000, 2'd0, 32'h4040_0000, 5'b00000);
    // R9 special operands
    one("R9 inf*zero",  32'h7F80_0000, 32'h0000_0000, 2'd0, 32'h7FC0_0000, 5'b00001);
    one("R9 snan",      32'h7F80_0001, 32'h3F80_0000, 2'd0, 32'h7FC0_0001, 5'b00001);
    one("R9 qnan src2", 32'h3F80_0000, 32'hFFC0_0005, 2'd0, 32'hFFC0_0005, 5'b00000);
    one("R9 inf*two",   32'hFF80_0000, 32'h4000_0000, 2'd0, 32'hFF80_0000, 5'b00000);
    one("R9 negzero",   32'h8000_0000, 32'h3F80_0000, 2'd0, 32'h8000_0000, 5'b00000);
    // R10 range limits
    one("R10 ovf near", 32'h7F00_0000, 32'h7F00_0000, 2'd0, 32'h7F80_0000, 5'b10100);
    one("R10 ovf zero", 32'h7F00_0000, 32'h7F00_0000, 2'd3, 32'h7F7F_FFFF, 5'b10100);
    one("R10 sub in",   32'h0000_0001, 32'h4B00_0000, 2'd0, 32'h0080_0000, 5'b00010);
    one("R10 tie even", 32'h0000_0001, 32'h3F00_0000, 2'd0, 32'h0000_0000, 5'b11010);
    one("R10 tie up",   32'h0000_0001, 32'h3F00_0000, 2'd2, 32'h0000_0001, 5'b11010);
    one("R10 sub exact",32'h0080_0000, 32'h3F00_0000, 2'd0, 32'h0040_0000, 5'b00000);
    // R11 flags only from multiplied lanes, OR across lanes
    pair("R11 masked invalid", 32'h7F80_0000, 32'h0, 32'h3F80_0000, 32'h3F80_0000,
         2'b10, 1'b0, 2'd0, 32'hA500_0000, 32'h3F80_0000, 5'b00000);
    pair("R11 or lanes", 32'h3F80_0001, 32'h3F80_0001, 32'h7F80_0000, 32'h0,
         2'b11, 1'b1, 2'd0, 32'h3F80_0002, 32'h7FC0_0000, 5'b10001);

    // R7 rounding source selection
    one("R7 setup", 32'h3F80_0001, 32'h3F80_0001, 2'd0, 32'h3F80_0002, 5'b10000);
    src1 = '0; src2 = '0; wmask = 16'h0001; mask_en = 1'b1; zero_mode = 1'b1;
    src1[31:0] = 32'h3F80_0001; src2[31:0] = 32'h3F80_0001;
    rc_static = 2'd2; rc_csr = 2'd0; bcast = 1'b1; src2_mem = 1'b0; vlen = 2'd2;
    issue();
    check("R7 static full", out_dst, {{(DW-32){1'b0}}, 32'h3F80_0003});
    vlen = 2'd1;
    issue();
    check("R7 csr half", out_dst, {{(DW-32){1'b0}}, 32'h3F80_0002});
    vlen = 2'd2; src2_mem = 1'b1;
    issue();
    check("R7 csr mem", out_dst, {{(DW-32){1'b0}}, 32'h3F80_0002});

    // R1 back-pressure
    src1 = '0; src2 = '0; mask_en = 1'b0; bcast = 1'b0; src2_mem = 1'b0; vlen = 2'd0;
    src1[31:0] = 32'h4000_0000; src2[31:0] = 32'h4000_0000;
    @(negedge clk);
    out_ready = 1'b0; in_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    src1[31:0] = 32'h4040_0000;
    held = out_dst;
    check("R1 stall valid", {{(DW-1){1'b0}}, out_valid}, {{(DW-1){1'b0}}, 1'b1});
    repeat (3) begin
      @(negedge clk);
      check("R1 stall in_ready", {{(DW-1){1'b0}}, in_ready}, '0);
      check("R1 stall hold", out_dst, held);
    end
    check("R1 first result", held, {{(DW-32){1'b0}}, 32'h4080_0000});
    out_ready = 1'b1;
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    check("R1 second result", out_dst, {{(DW-32){1'b0}}, 32'h40C0_0000});

    // R2 R3 R4 R5 R6 R12 random mix with exact products
    for (int it = 0; it < 60; it++) begin
      for (int j = 0; j < L; j++) begin
        src1[j*32 +: 32] = rnd_fp();
        src2[j*32 +: 32] = rnd_fp();
        old_dst[j*32 +: 32] = $urandom;
      end
      wmask = 16'($urandom);
      mask_en = 1'($urandom);
      zero_mode = 1'($urandom);
      vlen = 2'($urandom % 3);
      bcast = 1'($urandom);
      src2_mem = 1'($urandom);
      legacy = ($urandom % 5 == 0);
      rc_csr = 2'($urandom);
      rc_static = 2'($urandom);
      issue();
      check($sformatf("R2 R3 R4 R5 R6 R12 random %0d v%0d m%0d z%0d b%0d s%0d l%0d",
                      it, vlen, mask_en, zero_mode, bcast, src2_mem, legacy),
            out_dst, exp_vec());
      check("R11 random flags", {{(DW-5){1'b0}}, out_flags}, '0);
    end

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule